// File: doc/BRIEF.md
# Branch Record Store Writer

This block takes taken-branch events from a processor-side interface and turns each one into a fixed 24-byte record in a memory buffer. Each event carries a 64-bit source address, a 64-bit destination address and a prediction flag. The record goes out as three consecutive 64-bit words on a simple request/grant write port. Software programs the buffer base and limit and sets an enable control. It reads the current write pointer and a count of events the block could not store.

When the next record would not fit below the limit, the block raises an interrupt and stops writing. Software then saves the buffer and acknowledges the interrupt, which clears it and returns the write pointer to the base. A single holding register sits between the event input and the word sequencer. One event can wait there while a record is being written or while the write port stalls. Events that find no room are counted as dropped.

Top module: `branch_log_writer`

## Requirements
- R1: A record at pointer P is written as three words. P holds the source address, P+8 holds the destination address, and P+16 holds the prediction flag in bit 0 with bits 63:1 zero. The words go out in that order, one word per accepted grant.
- R2: The write pointer advances by 24 in the cycle after the third word of a record is granted.
- R3: While a write request is not granted, the request stays high and the address and data stay unchanged.
- R4: When the block is enabled, no record is in flight and pointer+24 exceeds the limit, the interrupt asserts on the next clock. While the interrupt is high, no write request is made.
- R5: An enabled event that arrives while the interrupt is pending is not written. It increments the dropped counter, which saturates at its maximum value of 2^DROP_W-1.
- R6: An acknowledge while the interrupt is high clears the interrupt and loads the base into the write pointer on the next clock.
- R7: An enabled event is taken into the one-entry holding register when that register is empty or is being handed to the sequencer in the same cycle. Otherwise the event is dropped and counted.
- R8: While the enable is low, events are ignored and not counted. The write pointer follows the base whenever no record is in flight.
- R9: After reset the interrupt, the write request, the dropped counter and the write pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Recording enable |
| cfg_base_i | input | 64 | Buffer base byte address |
| cfg_limit_i | input | 64 | Buffer end byte address (exclusive) |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| br_valid_i | input | 1 | Branch event strobe |
| br_src_i | input | 64 | Branch source address |
| br_dst_i | input | 64 | Branch destination address |
| br_pred_i | input | 1 | Branch prediction flag |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 64 | Write byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Write grant |
| wr_ptr_o | output | 64 | Current write pointer |
| drop_cnt_o | output | DROP_W | Saturating dropped-event count |
| irq_o | output | 1 | Buffer-full interrupt |

## Verification
The assertions run on every cycle. They check that a stalled request holds its address and data, and that no write is requested while the interrupt is high. They check that every write address lies below the limit and that the interrupt only rises when a record no longer fits. They also check that the dropped counter never decreases and stays put once saturated, and that an acknowledge restores the base. The bench scenarios cover what the assertions cannot. A behavioural model predicts every record's contents in memory and the exact drop count for back-to-back events against the holding register. The scenarios also show that disabled events leave every output untouched and that capture resumes correctly after an acknowledge under random grant stalls.

// File: rtl/blw_pkg.sv
package blw_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned REC_WORDS  = 3;
  localparam int unsigned REC_BYTES  = REC_WORDS * WORD_BYTES;
  localparam int unsigned IDX_W      = $clog2(REC_WORDS);
  localparam int unsigned WORD_SH    = $clog2(WORD_BYTES);

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic              pred;
  } br_rec_t;
endpackage

// File: rtl/blw_hold.sv
module blw_hold
  import blw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  br_rec_t rec_i,
  input  logic    pop_i,
  output logic    valid_o,
  output br_rec_t rec_o
);
  logic    valid_q;
  br_rec_t rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
    end else if (push_i) begin
      valid_q <= 1'b1;
      rec_q   <= rec_i;
    end else if (pop_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign rec_o   = rec_q;

  // R7
  hold_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!valid_q || pop_i));
  // R7
  hold_pop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_q);
endmodule

// File: rtl/blw_engine.sv
module blw_engine
  import blw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  br_rec_t           rec_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              last_o,
  output logic              busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  br_rec_t          rec_q;
  logic [REC_WORDS-1:0][WORD_W-1:0] words;

  // word order is the record layout
  assign words[0] = rec_q.src;
  assign words[1] = rec_q.dst;
  assign words[2] = {{(WORD_W-1){1'b0}}, rec_q.pred};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rec_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      rec_q  <= rec_i;
    end else if (busy_q && gnt_i) begin
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign req_o   = busy_q;
  assign addr_o  = ptr_i + (ADDR_W'(idx_q) << WORD_SH);
  assign wdata_o = words[idx_q];
  assign last_o  = busy_q && gnt_i && (idx_q == LAST_IDX);
  assign busy_o  = busy_q;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o && $stable(addr_o) && $stable(wdata_o)));
  // R1
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  // R1
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/blw_ctrl.sv
module blw_ctrl
  import blw_pkg::*;
#(
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              ack_i,
  input  logic              busy_i,
  input  logic              last_i,
  input  logic              drop_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              irq_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              fits_o
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [ADDR_W-1:0] ptr_q;
  logic              irq_q;
  logic [DROP_W-1:0] drop_q;
  logic              irq_set, irq_clr;

  assign fits_o  = ({1'b0, ptr_q} + (ADDR_W+1)'(REC_BYTES)) <= {1'b0, limit_i};
  assign irq_set = en_i && !busy_i && !irq_q && !fits_o;
  assign irq_clr = irq_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      irq_q  <= 1'b0;
      drop_q <= '0;
    end else begin
      if (irq_clr)      irq_q <= 1'b0;
      else if (irq_set) irq_q <= 1'b1;

      if (last_i)                         ptr_q <= ptr_q + ADDR_W'(REC_BYTES);
      else if (irq_clr || (!en_i && !busy_i)) ptr_q <= base_i;

      if (drop_i && (drop_q != DROP_MAX)) drop_q <= drop_q + 1'b1;
    end
  end

  assign ptr_o      = ptr_q;
  assign irq_o      = irq_q;
  assign drop_cnt_o = drop_q;

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(!fits_o && en_i));
  // R6
  ack_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> (!irq_o && ptr_o == $past(base_i)));
  // R5
  drop_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o == DROP_MAX) |=> (drop_cnt_o == DROP_MAX));
  // R5
  drop_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> (drop_cnt_o >= $past(drop_cnt_o)) && (drop_cnt_o != '0));
endmodule

// File: rtl/branch_log_writer.sv
module branch_log_writer
  import blw_pkg::*;
#(
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_limit_i,
  input  logic              irq_ack_i,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_src_i,
  input  logic [ADDR_W-1:0] br_dst_i,
  input  logic              br_pred_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              irq_o
);
  br_rec_t in_rec, hold_rec;
  logic    hold_v, busy, last, fits, start, accept, drop;

  assign in_rec = '{src: br_src_i, dst: br_dst_i, pred: br_pred_i};

  assign start  = hold_v && !busy && !irq_o && fits && cfg_en_i;
  assign accept = cfg_en_i && br_valid_i && !irq_o && (!hold_v || start);
  assign drop   = cfg_en_i && br_valid_i && !accept;

  blw_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .rec_i   (in_rec),
    .pop_i   (start),
    .valid_o (hold_v),
    .rec_o   (hold_rec)
  );

  blw_engine u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .rec_i   (hold_rec),
    .ptr_i   (wr_ptr_o),
    .gnt_i   (mem_gnt_i),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o),
    .last_o  (last),
    .busy_o  (busy)
  );

  blw_ctrl #(.DROP_W(DROP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg_en_i),
    .base_i     (cfg_base_i),
    .limit_i    (cfg_limit_i),
    .ack_i      (irq_ack_i),
    .busy_i     (busy),
    .last_i     (last),
    .drop_i     (drop),
    .ptr_o      (wr_ptr_o),
    .irq_o      (irq_o),
    .drop_cnt_o (drop_cnt_o),
    .fits_o     (fits)
  );

  // R4
  no_write_in_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mem_req_o);
  // R4
  addr_in_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (({1'b0, mem_addr_o} + (ADDR_W+1)'(WORD_BYTES)) <= {1'b0, cfg_limit_i}));
  // R8
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && !mem_req_o) |=> !mem_req_o);
endmodule

// File: tb/branch_log_writer_bench.sv
module branch_log_writer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        en = 0, ack = 0, valid = 0, pred = 0, gnt = 1;
  logic [63:0] base = 0, limit = 0, src = 0, dst = 0;
  logic        mem_req, irq;
  logic [63:0] mem_addr, mem_wdata, wr_ptr;
  logic [7:0]  drop_cnt;

  branch_log_writer u_branch_log_writer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_base_i(base),
    .cfg_limit_i(limit), .irq_ack_i(ack), .br_valid_i(valid),
    .br_src_i(src), .br_dst_i(dst), .br_pred_i(pred),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(gnt), .wr_ptr_o(wr_ptr), .drop_cnt_o(drop_cnt), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  int gnt_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_mem [logic [63:0]];

  typedef struct { logic [63:0] s; logic [63:0] d; logic p; } ev_t;
  ev_t  m_hold[$];
  ev_t  m_cur, ev_new;
  logic m_busy, m_irq;
  int   m_idx, m_drop;
  logic [63:0] m_ptr;
  logic m_fits, m_done, m_last, m_start, m_set, m_acc, m_busy_old;

  function automatic logic [63:0] word_of(ev_t e, int i);
    if (i == 0) return e.s;
    if (i == 1) return e.d;
    return {63'b0, e.p};
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold.delete();
      m_busy = 0; m_irq = 0; m_idx = 0; m_drop = 0; m_ptr = 0;
    end else begin
      m_fits  = ({1'b0, m_ptr} + 65'd24) <= {1'b0, limit};
      m_done  = m_busy && gnt;
      m_last  = m_done && m_idx == 2;
      m_start = m_hold.size() > 0 && !m_busy && !m_irq && m_fits && en;
      m_set   = en && !m_busy && !m_irq && !m_fits;
      m_acc   = en && valid && !m_irq && (m_hold.size() == 0 || m_start);
      m_busy_old = m_busy;
      ev_new = '{s: src, d: dst, p: pred};
      if (m_done) exp_mem[m_ptr + 64'(8 * m_idx)] = word_of(m_cur, m_idx);
      if (m_last) begin m_busy = 0; m_idx = 0; end
      else if (m_done) m_idx++;
      if (m_last) m_ptr = m_ptr + 24;
      else if ((m_irq && ack) || (!en && !m_busy_old)) m_ptr = base;
      if (m_irq && ack) m_irq = 0;
      else if (m_set) m_irq = 1;
      if (m_start) begin m_cur = m_hold.pop_front(); m_busy = 1; m_idx = 0; end
      if (m_acc) m_hold.push_back(ev_new);
      if (en && valid && !m_acc && m_drop < 255) m_drop++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(irq == m_irq, "R4", "irq", 64'(irq), 64'(m_irq));
    chk(wr_ptr == m_ptr, "R2", "wr_ptr", wr_ptr, m_ptr);
    chk(drop_cnt == 8'(m_drop), "R5", "drop_cnt", 64'(drop_cnt), 64'(m_drop));
    chk(mem_req == m_busy, "R1", "mem_req", 64'(mem_req), 64'(m_busy));
    if (m_busy && mem_req) begin
      chk(mem_addr == m_ptr + 64'(8 * m_idx), "R1", "mem_addr", mem_addr, m_ptr + 64'(8 * m_idx));
      chk(mem_wdata == word_of(m_cur, m_idx), "R1", "mem_wdata", mem_wdata, word_of(m_cur, m_idx));
    end
  endtask

  task automatic tick();
    if (mem_req && gnt) mem[mem_addr] = mem_wdata;
    @(posedge clk);
    @(negedge clk);
    compare_all();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (gnt_mode)
      0: gnt = 1;
      1: gnt = 0;
      default: gnt = lfsr[0] | lfsr[3];
    endcase
  endtask

  task automatic event_once(input logic [63:0] s, input logic [63:0] d, input logic p);
    valid = 1; src = s; dst = d; pred = p;
    tick();
    valid = 0;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] a;
    logic        hold_req;
    repeat (2) tick();
    // R9 reset state
    chk(irq == 0 && mem_req == 0 && drop_cnt == 0 && wr_ptr == 0, "R9", "reset outputs",
        {wr_ptr[31:0], 8'(drop_cnt), 22'b0, mem_req, irq}, 64'h0);
    rst_n = 1;
    base = 64'h1000; limit = 64'h1000 + 64'd192;
    tick();
    // R8 disabled: events ignored, pointer follows base
    for (int i = 0; i < 5; i++) event_once(64'h100 + 64'(i), 64'h200, 1);
    tick();
    chk(drop_cnt == 0 && mem_req == 0, "R8", "disabled events ignored", 64'(drop_cnt), 0);
    chk(wr_ptr == base, "R8", "ptr follows base", wr_ptr, base);

    en = 1; tick();
    // R7 six back-to-back events: three dropped
    for (int i = 0; i < 6; i++) begin
      valid = 1; src = 64'hA000 + 64'(i); dst = 64'hB000 + 64'(i); pred = i[0];
      tick();
    end
    valid = 0;
    chk(drop_cnt == 3, "R7", "back-to-back drops", 64'(drop_cnt), 3);
    repeat (10) tick();
    chk(wr_ptr == base + 64'd72, "R2", "ptr after three records", wr_ptr, base + 64'd72);

    // R3 stalled grant
    gnt_mode = 1; gnt = 0;
    event_once(64'hC0DE, 64'hD00D, 1);
    tick();
    a = mem_addr; hold_req = mem_req;
    repeat (3) tick();
    chk(hold_req && mem_req && mem_addr == a, "R3", "stall holds address", mem_addr, a);
    gnt_mode = 0; gnt = 1;
    repeat (6) tick();
    chk(mem[base + 64'd72] == 64'hC0DE && mem[base + 64'd80] == 64'hD00D &&
        mem[base + 64'd88] == 64'd1, "R1", "record layout", mem[base + 64'd88], 64'd1);

    // R4 fill remaining four records
    for (int i = 0; i < 4; i++) begin
      event_once(64'hE000 + 64'(i), 64'hF000 + 64'(i), 0);
      repeat (6) tick();
    end
    chk(irq == 1, "R4", "irq on full", 64'(irq), 1);
    chk(wr_ptr == base + 64'd192, "R4", "ptr at limit", wr_ptr, base + 64'd192);

    // R5 events during irq, saturation
    valid = 1;
    for (int i = 0; i < 300; i++) begin src = 64'(i); tick(); end
    valid = 0;
    chk(drop_cnt == 8'hFF, "R5", "drop saturates", 64'(drop_cnt), 64'hFF);
    chk(mem_req == 0, "R5", "no writes during irq", 64'(mem_req), 0);

    // R6 acknowledge
    ack = 1; tick(); ack = 0;
    chk(irq == 0 && wr_ptr == base, "R6", "ack rearm", wr_ptr, base);

    // random traffic with stalls and acknowledges
    base = 64'h2000; limit = 64'h2000 + 64'd127;
    en = 0; tick(); en = 1;
    gnt_mode = 2;
    for (int i = 0; i < 600; i++) begin
      valid = lfsr[5] & lfsr[9];
      src = {48'h0, lfsr}; dst = 64'(i) << 4; pred = lfsr[2];
      ack = irq && lfsr[7];
      tick();
    end
    valid = 0; ack = 0; gnt_mode = 0;
    repeat (10) tick();

    foreach (exp_mem[k])
      chk(mem.exists(k) && mem[k] == exp_mem[k], "R1", "memory word", mem.exists(k) ? mem[k] : 64'hX, exp_mem[k]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule